// File: doc/BRIEF.md
# Playback Byte Counter Interrupt Generator

This block counts the playback bytes that a DMA stream delivers and raises a host interrupt once a programmed block has been consumed. Software programs the block length as a 16-bit sample count, written as an upper and a lower byte. The block converts that count into a byte threshold with a left shift. The shift depends on whether the stream is mono or stereo and on whether each sample is one byte (plain 8-bit or companded) or two bytes (16-bit linear).

The DMA request is held high while playback is enabled and the selected format is a valid one. Each rise of the request zeroes the transferred-byte counter. When the counter reaches the threshold, the block pulses two set strobes, one for the status interrupt bit and one for the playback-interrupt flag. It raises the interrupt line and reloads the counter to zero, so the next interrupt comes after another full block. A clear input from the register file drops the interrupt line.

Top module: `pbc_irq_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), dma_req, irq, int_set and pflag_set are all 0.
- R2: The sample count is {cnt_hi, cnt_lo}, with cnt_hi as bits 15:8. The byte threshold is that count shifted left by S. S = 0 for mono byte-wide data, 1 for stereo byte-wide data, 1 for mono 16-bit data and 2 for stereo 16-bit data.
- R3: When fmt_ext = 0, only fmt_code[1:0] is decoded. When fmt_ext = 1, all three bits are decoded. The codes are: 0 = unsigned 8-bit, 1 and 3 = companded (byte-wide), 2 and 6 = 16-bit linear. Codes 4, 5 and 7 are invalid.
- R4: dma_req goes to 1 on the clock edge after play_en = 1 with a valid format. It goes to 0 on the edge after play_en = 0 or after the format becomes invalid.
- R5: Every 0-to-1 transition of dma_req zeroes the transferred-byte counter, so a block that was partly counted before a restart does not carry over.
- R6: A byte_ack is counted only when irq_en = 1 and dma_req = 1. Otherwise it is ignored and the counter keeps its value.
- R7: The byte_ack that brings the count to the threshold makes int_set and pflag_set pulse high for one cycle and sets irq on the next edge. The counter reloads to zero, so the following interrupt needs another full threshold of bytes.
- R8: irq stays high until irq_clr is applied. A clear in the same cycle as a new threshold hit does not win, and irq stays high.
- R9: A sample count of zero never produces an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_ack | input | 1 | One playback byte accepted this cycle |
| cnt_hi | input | 8 | Upper byte of the sample count |
| cnt_lo | input | 8 | Lower byte of the sample count |
| irq_en | input | 1 | Enables counting and interrupts |
| play_en | input | 1 | Playback enable |
| stereo | input | 1 | 1 = two channels |
| fmt_code | input | 3 | Sample format code |
| fmt_ext | input | 1 | 1 = decode all three format bits |
| irq_clr | input | 1 | Clears the interrupt line |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Host interrupt line |
| int_set | output | 1 | One-cycle set pulse for the status interrupt bit |
| pflag_set | output | 1 | One-cycle set pulse for the playback-interrupt flag |

## Verification
The assertions check the following on every cycle:
- dma_req is low whenever playback was off in the previous cycle.
- No set pulse follows a cycle in which counting was disabled or the request was low.
- A set pulse always comes with a high irq.
- irq holds until a clear, and a clear drops irq unless a hit arrives in the same cycle.

Only the bench scenarios can show the exact byte on which each interrupt lands for every format and shift. They also cover the reload after a hit, the restart zeroing, format masking with fmt_ext low and the silence of a zero count.

// File: rtl/pbc_pkg.sv
// Shared constants and format decode helper for the playback byte counter.
package pbc_pkg;
    localparam int FMT_W   = 3;
    localparam int SHIFT_W = 2;

    typedef enum logic [1:0] {
        SK_BYTE    = 2'd0,
        SK_WORD    = 2'd1,
        SK_INVALID = 2'd2
    } sample_kind_t;

    // Classifies a masked format code into byte-wide, 16-bit or invalid.
    function automatic sample_kind_t kind_of(input logic [FMT_W-1:0] code);
        case (code)
            3'd0, 3'd1, 3'd3: kind_of = SK_BYTE;
            3'd2, 3'd6:       kind_of = SK_WORD;
            default:          kind_of = SK_INVALID;
        endcase
    endfunction
endpackage

// File: rtl/pbc_fmt_decode.sv
// Format decoder: masks the code by fmt_ext, flags invalid codes and
// produces the byte-per-sample shift. Purely combinational.
module pbc_fmt_decode
    import pbc_pkg::*;
(
    input  logic [FMT_W-1:0]   fmt_code,
    input  logic               fmt_ext,
    input  logic               stereo,
    output logic               fmt_ok,
    output logic [SHIFT_W-1:0] shift
);
    logic [FMT_W-1:0] masked;
    sample_kind_t     kind;

    // Mask the code and derive validity and shift.
    always_comb begin
        masked = fmt_ext ? fmt_code : {1'b0, fmt_code[1:0]};
        kind   = kind_of(masked);
        fmt_ok = (kind != SK_INVALID);
        if (kind == SK_WORD) shift = stereo ? 2'd2 : 2'd1;
        else                 shift = stereo ? 2'd1 : 2'd0;
    end
endmodule

// File: rtl/pbc_dma_gate.sv
// DMA request register. Also reports the cycle in which the request
// is about to rise, so the counter can restart. Assumes a synchronous reset.
module pbc_dma_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic play_en,
    input  logic fmt_ok,
    output logic dma_req,
    output logic start
);
    logic want;

    // The request is wanted when playback is on and the format is valid.
    always_comb begin
        want  = play_en & fmt_ok;
        start = want & ~dma_req;
    end

    // Register the request.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_req <= 1'b0;
        else        dma_req <= want;
    end
endmodule

// File: rtl/pbc_byte_counter.sv
// Transferred-byte counter compared against the count shifted into bytes.
// Assumes count and shift are stable while bytes flow.
module pbc_byte_counter #(
    parameter int CNT_W     = 16,
    parameter int SHIFT_MAX = 2,
    parameter int SHIFT_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   count,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               count_en,
    input  logic               byte_ack,
    input  logic               start,
    output logic               hit
);
    localparam int ACC_W = CNT_W + SHIFT_MAX;

    logic [ACC_W-1:0] done_q;
    logic [ACC_W-1:0] thr;
    logic [ACC_W-1:0] nxt;
    logic             step;

    // Build the byte threshold and detect the completing byte.
    always_comb begin
        thr  = {{SHIFT_MAX{1'b0}}, count} << shift;
        nxt  = done_q + 1'b1;
        step = byte_ack & count_en & ~start;
        hit  = step & (thr != '0) & (nxt == thr);
    end

    // Advance, reload on hit, zero on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)     done_q <= '0;
        else if (start) done_q <= '0;
        else if (hit)   done_q <= '0;
        else if (step)  done_q <= nxt;
    end
endmodule

// File: rtl/pbc_irq_latch.sv
// Interrupt line and set pulses. A hit takes priority over a clear
// in the same cycle. Assumes a synchronous reset.
module pbc_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic irq_clr,
    output logic irq,
    output logic set_pulse
);
    // Latch the line and register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq       <= 1'b0;
            set_pulse <= 1'b0;
        end else begin
            set_pulse <= hit;
            if (hit)          irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/pbc_irq_gen.sv
// Playback byte counter interrupt generator: the top level joining the
// format decoder, the DMA gate, the byte counter and the interrupt latch.
module pbc_irq_gen
    import pbc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int HALF  = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_ack,
    input  logic [HALF-1:0]  cnt_hi,
    input  logic [HALF-1:0]  cnt_lo,
    input  logic             irq_en,
    input  logic             play_en,
    input  logic             stereo,
    input  logic [FMT_W-1:0] fmt_code,
    input  logic             fmt_ext,
    input  logic             irq_clr,
    output logic             dma_req,
    output logic             irq,
    output logic             int_set,
    output logic             pflag_set
);
    logic               fmt_ok;
    logic [SHIFT_W-1:0] shift;
    logic               start;
    logic               hit;
    logic               set_pulse;
    logic [CNT_W-1:0]   count;

    // Assemble the sample count from its two halves.
    always_comb count = {cnt_hi, cnt_lo};

    pbc_fmt_decode u_fmt (
        .fmt_code(fmt_code), .fmt_ext(fmt_ext), .stereo(stereo),
        .fmt_ok(fmt_ok), .shift(shift)
    );

    pbc_dma_gate u_gate (
        .clk(clk), .rst_n(rst_n), .play_en(play_en), .fmt_ok(fmt_ok),
        .dma_req(dma_req), .start(start)
    );

    pbc_byte_counter #(.CNT_W(CNT_W), .SHIFT_MAX(2), .SHIFT_W(SHIFT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .count(count), .shift(shift),
        .count_en(irq_en & dma_req), .byte_ack(byte_ack), .start(start),
        .hit(hit)
    );

    pbc_irq_latch u_irq (
        .clk(clk), .rst_n(rst_n), .hit(hit), .irq_clr(irq_clr),
        .irq(irq), .set_pulse(set_pulse)
    );

    // Both status strobes come from the same completion event.
    always_comb begin
        int_set   = set_pulse;
        pflag_set = set_pulse;
    end
endmodule

// File: rtl/pbc_irq_gen_chk.sv
// Checker for pbc_irq_gen, bound to every instance of the top.
module pbc_irq_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic play_en,
    input logic irq_en,
    input logic irq_clr,
    input logic dma_req,
    input logic irq,
    input logic int_set
);
    // R4: no request unless playback was enabled one cycle earlier.
    p_dma_needs_play_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |=> !dma_req);

    // R6: disabled interrupts mean no set pulse after that cycle.
    p_no_hit_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !int_set);

    // R6: no counting while the request is low.
    p_no_hit_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req |=> !int_set);

    // R7: a set pulse always comes with the line raised.
    p_pulse_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_set |-> irq);

    // R8: the line holds without a clear.
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R8: a clear drops the line unless a hit lands in the same cycle.
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> (int_set || !irq));
endmodule

bind pbc_irq_gen pbc_irq_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .irq_en(irq_en),
    .irq_clr(irq_clr), .dma_req(dma_req), .irq(irq), .int_set(int_set)
);

// File: tb/pbc_irq_gen_bench.sv
module pbc_irq_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_ack = 1'b0;
    logic [7:0] cnt_hi = '0, cnt_lo = '0;
    logic       irq_en = 1'b0, play_en = 1'b0, stereo = 1'b0;
    logic [2:0] fmt_code = '0;
    logic       fmt_ext = 1'b0, irq_clr = 1'b0;
    logic       dma_req, irq, int_set, pflag_set;

    int total = 0;
    int bad = 0;
    int hits;
    bit last_hit;

    always #2.5 clk = ~clk;

    pbc_irq_gen u_pbc_irq_gen (
        .clk(clk), .rst_n(rst_n), .byte_ack(byte_ack), .cnt_hi(cnt_hi),
        .cnt_lo(cnt_lo), .irq_en(irq_en), .play_en(play_en), .stereo(stereo),
        .fmt_code(fmt_code), .fmt_ext(fmt_ext), .irq_clr(irq_clr),
        .dma_req(dma_req), .irq(irq), .int_set(int_set), .pflag_set(pflag_set)
    );

    // Vector: ext, fmt, stereo, hi, lo, expected bytes per interrupt (R2, R3)
    localparam int NV = 9;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 3'd0, 1'b0, 8'd0, 8'd5, 18'd5},
        {1'b0, 3'd0, 1'b1, 8'd0, 8'd5, 18'd10},
        {1'b0, 3'd1, 1'b1, 8'd0, 8'd3, 18'd6},
        {1'b0, 3'd2, 1'b0, 8'd0, 8'd3, 18'd6},
        {1'b0, 3'd2, 1'b1, 8'd0, 8'd3, 18'd12},
        {1'b1, 3'd6, 1'b1, 8'd0, 8'd2, 18'd8},
        {1'b1, 3'd3, 1'b0, 8'd0, 8'd7, 18'd7},
        {1'b0, 3'd6, 1'b0, 8'd0, 8'd4, 18'd8},
        {1'b0, 3'd0, 1'b0, 8'd1, 8'd2, 18'd258}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sends n bytes, two cycles each; counts set pulses seen.
    task automatic send(input int n);
        hits = 0;
        last_hit = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) byte_ack = 1'b1;
            @(negedge clk) byte_ack = 1'b0;
            last_hit = int_set;
            if (int_set) begin
                hits++;
                if (!pflag_set) chk(1'b0, "R7 pflag_set", 0, 1);
            end
        end
    endtask

    task automatic clear_irq();
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic setup(input bit e, input logic [2:0] f, input bit s,
                         input logic [7:0] h, input logic [7:0] l);
        @(negedge clk);
        play_en = 1'b0;
        fmt_ext = e; fmt_code = f; stereo = s; cnt_hi = h; cnt_lo = l;
        irq_en = 1'b1;
        wait_cyc(2);
        play_en = 1'b1;
        wait_cyc(2);
    endtask

    initial begin : watchdog
        #800000;
        bad++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(3);
        chk(!dma_req && !irq && !int_set && !pflag_set, "R1 reset", {dma_req, irq, int_set}, 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // Table walk: R2, R3, R7
        for (int v = 0; v < NV; v++) begin
            setup(VEC[v][38], VEC[v][37:35], VEC[v][34], VEC[v][33:26], VEC[v][25:18]);
            chk(dma_req, "R4 dma_req up", dma_req, 1);
            send(int'(VEC[v][17:0]) - 1);
            chk(hits == 0, "R2 early hit", hits, 0);
            send(1);
            chk(last_hit && irq, "R2 threshold hit", last_hit, 1);
            clear_irq();
            chk(!irq, "R8 cleared", irq, 0);
        end

        // R3: invalid codes with full decode, masked with short decode
        setup(1'b1, 3'd5, 1'b0, 8'd0, 8'd2);
        chk(!dma_req, "R3 code 5 invalid", dma_req, 0);
        setup(1'b1, 3'd4, 1'b0, 8'd0, 8'd2);
        chk(!dma_req, "R3 code 4 invalid", dma_req, 0);
        setup(1'b0, 3'd5, 1'b0, 8'd0, 8'd2);
        chk(dma_req, "R3 code 5 masked to 1", dma_req, 1);

        // R4: request drops when the format turns invalid, then on play_en low
        @(negedge clk) fmt_ext = 1'b1;
        @(negedge clk);
        chk(!dma_req, "R4 drop on invalid", dma_req, 0);
        fmt_ext = 1'b0;
        @(negedge clk);
        chk(dma_req, "R4 back up", dma_req, 1);
        play_en = 1'b0;
        @(negedge clk);
        chk(!dma_req, "R4 drop on play off", dma_req, 0);

        // R6: bytes ignored while interrupts disabled or while idle
        setup(1'b0, 3'd0, 1'b0, 8'd0, 8'd3);
        irq_en = 1'b0;
        send(10);
        chk(hits == 0, "R6 disabled no hit", hits, 0);
        play_en = 1'b0; irq_en = 1'b1;
        send(10);
        chk(hits == 0, "R6 idle no hit", hits, 0);
        play_en = 1'b1;
        wait_cyc(2);
        send(2);
        chk(hits == 0, "R6 count held", hits, 0);
        send(1);
        chk(last_hit, "R6 hit after third byte", last_hit, 1);

        // R7: reload, next interrupt after another full block
        send(2);
        chk(hits == 0, "R7 reload early", hits, 0);
        send(1);
        chk(last_hit, "R7 reload hit", last_hit, 1);

        // R8: clear in the same cycle as a hit loses
        send(2);
        @(negedge clk) begin byte_ack = 1'b1; irq_clr = 1'b1; end
        @(negedge clk) begin byte_ack = 1'b0; irq_clr = 1'b0; end
        chk(irq && int_set, "R8 set beats clear", irq, 1);
        wait_cyc(3);
        chk(irq, "R8 holds", irq, 1);
        clear_irq();
        chk(!irq, "R8 clear", irq, 0);

        // R5: restart zeroes a partial count
        setup(1'b0, 3'd0, 1'b0, 8'd0, 8'd5);
        send(3);
        @(negedge clk) play_en = 1'b0;
        wait_cyc(2);
        play_en = 1'b1;
        wait_cyc(2);
        send(4);
        chk(hits == 0, "R5 no carry over", hits, 0);
        send(1);
        chk(last_hit, "R5 full block after restart", last_hit, 1);
        clear_irq();

        // R9: a zero count never interrupts
        setup(1'b0, 3'd2, 1'b1, 8'd0, 8'd0);
        send(300);
        chk(hits == 0 && !irq, "R9 zero count silent", hits, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule